// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary up-counter. It defaults to 4 bits and wraps to zero after its all-ones state. On a rising clock edge it can be cleared, loaded from a parallel data input, advanced by one, or left unchanged. Which of these happens depends on a small set of control inputs with a fixed priority. A build parameter chooses whether the active-low reset clears the count at once or waits for the next rising clock edge.

Two count enables are provided so that wider counters can be built from several stages without any extra logic. The count advances only when both enables are high. Only the trickle enable also gates the terminal-count flag. That flag is high when the count is all ones and the trickle enable is high. It is decoded combinationally from the registered count and the trickle-enable input. A following stage can therefore take it directly as its own trickle enable and advance in the same clock cycle. A shared parallel enable starts and stops the whole chain together.

Top module: `cascadable_counter`

## Requirements
- R1: With ASYNC_RST=1, a low rst_n forces count to zero at once, without waiting for a clock edge, and keeps it there while rst_n stays low.
- R2: With ASYNC_RST=0, a low rst_n has no effect on count until the next rising clock edge, at which count becomes zero.
- R3: Reset has the highest priority: it clears the count even when a load or a count is requested in the same cycle.
- R4: When reset is inactive and load_n is low, count takes the value of din on the next rising edge, whatever en_par and en_trk are.
- R5: When reset is inactive, load_n is high and en_par and en_trk are both high, count increases by one on the next rising edge.
- R6: When reset is inactive, load_n is high and either en_par or en_trk is low, count keeps its value across the edge.
- R7: Counting from the all-ones value (15 at the default width) gives zero.
- R8: tc is high exactly when en_trk is high and count is all ones. It does not depend on en_par or load_n, and it follows en_trk without waiting for a clock edge.
- R9: Two instances can be chained by feeding the lower stage's tc into the upper stage's en_trk and sharing en_par and load_n. The pair then counts as one 8-bit counter, including the wrap from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all synchronous changes happen on its rising edge |
| rst_n | input | 1 | Active-low reset; asynchronous or synchronous, chosen by ASYNC_RST |
| load_n | input | 1 | Active-low parallel load request |
| din | input | COUNTER_WIDTH | Parallel data copied into the count on a load |
| en_par | input | 1 | Parallel count enable; affects counting only |
| en_trk | input | 1 | Trickle count enable; affects counting and gates tc |
| count | output | COUNTER_WIDTH | Registered count value |
| tc | output | 1 | Terminal-count flag: en_trk high and count all ones |

## Verification
The two functions that can coincide are reset and parallel load. The bench requests a load while both count enables are high, then drops rst_n in the middle of that same clock cycle. The asynchronous instance must read zero before the next edge. The synchronous instance must still hold its old value at that point, and must read zero rather than the requested data after the edge. The second overlap is counting and the terminal flag: at all ones, the bench checks both the wrap to zero and the carry into a second chained stage, which happen in the same cycle.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  // Operation chosen for the next rising edge when reset is not active.
  typedef enum logic [1:0] {
    M_HOLD  = 2'd0,
    M_COUNT = 2'd1,
    M_LOAD  = 2'd2
  } cnt_mode_e;

endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
  import cnt_pkg::*;
(
  input  logic      load_n,
  input  logic      en_par,
  input  logic      en_trk,
  output cnt_mode_e mode,
  output logic      ev_load,
  output logic      ev_incr,
  output logic      ev_hold
);

  // Load wins over counting; counting needs both enables.
  function automatic cnt_mode_e f_pick(input logic ld_n, input logic ep, input logic et);
    if (!ld_n)        return M_LOAD;
    else if (ep && et) return M_COUNT;
    else              return M_HOLD;
  endfunction

  always_comb begin
    mode    = f_pick(load_n, en_par, en_trk);
    ev_load = (mode == M_LOAD);
    ev_incr = (mode == M_COUNT);
    ev_hold = (mode == M_HOLD);
  end

endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg
  import cnt_pkg::*;
#(
  parameter int W         = 4,
  parameter bit ASYNC_RST = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cnt_mode_e    mode,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  logic [W-1:0] nxt;

  // Modulo-2^W increment.
  function automatic logic [W-1:0] f_next(input logic [W-1:0] v);
    return v + {{(W-1){1'b0}}, 1'b1};
  endfunction

  always_comb begin
    unique case (mode)
      M_LOAD:  nxt = din;
      M_COUNT: nxt = f_next(q);
      default: nxt = q;
    endcase
  end

  generate
    if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
      end

      // R1: count is zero at every edge while reset is held
      always @(posedge clk) begin
        if (!rst_n) begin
          p_async_clear_r1: assert (q == '0)
            else $error("async reset did not clear");
        end
      end
    end else begin : g_sync
      logic clr_seen_q;

      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
      end

      always_ff @(posedge clk) clr_seen_q <= !rst_n;

      // R2, R3: an edge with reset low leaves zero, even when load or count was requested
      always @(posedge clk) begin
        if (clr_seen_q) begin
          p_sync_clear_r2: assert (q == '0)
            else $error("sync reset did not clear");
        end
      end
    end
  endgenerate

  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_LOAD) |=> (q == $past(din)));

  p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_COUNT) |=> (q == W'($past(q) + 1)));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_HOLD) |=> $stable(q));

endmodule

// File: rtl/cnt_tc_dec.sv
module cnt_tc_dec #(
  parameter int W = 4
) (
  input  logic [W-1:0] q,
  input  logic         en_trk,
  output logic         tc,
  output logic         at_max
);

  localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

  function automatic logic f_is_max(input logic [W-1:0] v);
    return v == MAX_VAL;
  endfunction

  always_comb begin
    at_max = f_is_max(q);
    tc     = at_max && en_trk;
  end

endmodule

// File: rtl/cascadable_counter.sv
module cascadable_counter
  import cnt_pkg::*;
#(
  parameter int COUNTER_WIDTH = 4,
  parameter bit ASYNC_RST     = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_n,
  input  logic [COUNTER_WIDTH-1:0] din,
  input  logic                     en_par,
  input  logic                     en_trk,
  output logic [COUNTER_WIDTH-1:0] count,
  output logic                     tc
);

  localparam int W = COUNTER_WIDTH;

  cnt_mode_e mode;
  logic      ev_load, ev_incr, ev_hold;
  logic      at_max;
  logic      ev_wrap;

  cnt_mode_dec u_dec (
    .load_n  (load_n),
    .en_par  (en_par),
    .en_trk  (en_trk),
    .mode    (mode),
    .ev_load (ev_load),
    .ev_incr (ev_incr),
    .ev_hold (ev_hold)
  );

  cnt_state_reg #(.W(W), .ASYNC_RST(ASYNC_RST)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .mode  (mode),
    .din   (din),
    .q     (count)
  );

  cnt_tc_dec #(.W(W)) u_tc (
    .q      (count),
    .en_trk (en_trk),
    .tc     (tc),
    .at_max (at_max)
  );

  assign ev_wrap = ev_incr && at_max;

  // R7: counting from all ones lands on zero
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrap |=> (count == '0));

  // R8: tc only with trickle enable high and count at all ones
  p_tc_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (en_trk && (count == {W{1'b1}})));

  // R8: a counting edge that starts with tc high must wrap
  p_tc_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && load_n && en_par) |=> (count == '0));

  // Exactly one of the three modes is chosen in every cycle
  p_mode_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({ev_load, ev_incr, ev_hold}));

endmodule

// File: tb/sim_cascadable_counter.sv
`timescale 1ns/1ps
module sim_cascadable_counter;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;

  // Shared stimulus for the async (u0) and sync (u1) 4-bit instances
  logic       rst_n  = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] din    = '0;
  logic       en_par = 1'b0;
  logic       en_trk = 1'b0;
  logic [3:0] cnt_a, cnt_s;
  logic       tc_a, tc_s;

  cascadable_counter #(.COUNTER_WIDTH(4), .ASYNC_RST(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
    .en_par(en_par), .en_trk(en_trk), .count(cnt_a), .tc(tc_a));

  cascadable_counter #(.COUNTER_WIDTH(4), .ASYNC_RST(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .din(din),
    .en_par(en_par), .en_trk(en_trk), .count(cnt_s), .tc(tc_s));

  // Two-stage chain
  logic       c_rst_n  = 1'b0;
  logic       c_load_n = 1'b1;
  logic [7:0] c_din    = '0;
  logic       c_en     = 1'b0;
  logic [3:0] lo_q, hi_q;
  logic       lo_tc, hi_tc;

  cascadable_counter u_lo (
    .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .din(c_din[3:0]),
    .en_par(c_en), .en_trk(1'b1), .count(lo_q), .tc(lo_tc));

  cascadable_counter u_hi (
    .clk(clk), .rst_n(c_rst_n), .load_n(c_load_n), .din(c_din[7:4]),
    .en_par(c_en), .en_trk(lo_tc), .count(hi_q), .tc(hi_tc));

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {load_n, en_par, en_trk, din[3:0], exp_count[3:0], exp_tc}
  localparam int NV = 12;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 4'd5,  4'd5,  1'b0},  // R4 load with enables low
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd6,  1'b0},  // R5 count
    {1'b1, 1'b0, 1'b1, 4'd0,  4'd6,  1'b0},  // R6 en_par low holds
    {1'b1, 1'b1, 1'b0, 4'd0,  4'd6,  1'b0},  // R6 en_trk low holds
    {1'b0, 1'b1, 1'b1, 4'd14, 4'd14, 1'b0},  // R4 load beats count
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd15, 1'b1},  // R5 R8 reach all ones
    {1'b1, 1'b0, 1'b1, 4'd0,  4'd15, 1'b1},  // R8 tc ignores en_par
    {1'b1, 1'b1, 1'b0, 4'd0,  4'd15, 1'b0},  // R8 tc gated by en_trk
    {1'b0, 1'b1, 1'b1, 4'd15, 4'd15, 1'b1},  // R8 tc ignores load_n
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0},  // R7 wrap to zero
    {1'b1, 1'b1, 1'b1, 4'd0,  4'd1,  1'b0},  // R5 count after wrap
    {1'b0, 1'b0, 1'b0, 4'd9,  4'd9,  1'b0}   // R4 preset for reset test
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int exp8;
    repeat (2) @(negedge clk);
    en_trk = 1'b1;
    #1;
    // R1 reset state; tc low since count is not all ones
    chk("R1 reset count async", cnt_a, 0);
    chk("R1 reset tc", tc_a, 0);
    chk("R2 reset count sync", cnt_s, 0);
    @(negedge clk);
    rst_n = 1'b1;
    c_rst_n = 1'b1;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      load_n = VEC[i][11];
      en_par = VEC[i][10];
      en_trk = VEC[i][9];
      din    = VEC[i][8:5];
      @(posedge clk);
      #2;
      chk($sformatf("R4-R8 vec%0d async count", i), cnt_a, int'(VEC[i][4:1]));
      chk($sformatf("R4-R8 vec%0d sync count", i), cnt_s, int'(VEC[i][4:1]));
      chk($sformatf("R8 vec%0d tc", i), tc_a, int'(VEC[i][0]));
    end

    // R8: tc follows en_trk without a clock edge
    @(negedge clk);
    load_n = 1'b0; din = 4'd15; en_par = 1'b0; en_trk = 1'b0;
    @(posedge clk); #2;
    load_n = 1'b1;
    en_trk = 1'b1; #1;
    chk("R8 tc rises with en_trk between edges", tc_a, 1);
    en_trk = 1'b0; #1;
    chk("R8 tc falls with en_trk between edges", tc_a, 0);

    // R1 R2 R3: reset dropped mid-cycle while a load and count are requested
    @(negedge clk);
    load_n = 1'b0; din = 4'd9; en_par = 1'b0; en_trk = 1'b0;
    @(posedge clk); #1;
    load_n = 1'b0; din = 4'd12; en_par = 1'b1; en_trk = 1'b1;
    #1 rst_n = 1'b0;
    #1;
    chk("R1 async clears without clock", cnt_a, 0);
    chk("R2 sync waits for edge", cnt_s, 9);
    @(posedge clk); #2;
    chk("R3 sync reset beats load", cnt_s, 0);
    chk("R1 async stays cleared", cnt_a, 0);
    @(negedge clk);
    rst_n = 1'b1; load_n = 1'b1; en_par = 1'b0;
    @(posedge clk); #2;
    chk("R6 hold after reset", cnt_s, 0);

    // R9: two-stage chain through 255 -> 0
    @(negedge clk);
    c_load_n = 1'b0; c_din = 8'hFD; c_en = 1'b0;
    @(posedge clk); #2;
    chk("R9 chain load", {hi_q, lo_q}, 8'hFD);
    exp8 = 8'hFD;
    @(negedge clk);
    c_load_n = 1'b1; c_en = 1'b1;
    for (int k = 0; k < 270; k++) begin
      @(posedge clk); #2;
      exp8 = (exp8 + 1) % 256;
      chk($sformatf("R9 chain step %0d", k), {hi_q, lo_q}, exp8);
    end
    @(negedge clk);
    c_en = 1'b0;
    @(posedge clk); #2;
    chk("R9 chain hold", {hi_q, lo_q}, exp8);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule